// File: doc/BRIEF.md
# Dithered Variable Period Oscillator

This block produces the square-wave switching clock for a resonant power stage. The period comes from a fixed-point command, given in system clock cycles. The command has an integer part and a fraction. A counter can only make whole-cycle periods. A first-order error-feedback stage therefore moves each cycle's rounding error into the next period. As a result, the run of integer periods averages to the fractional command. Without this stage, the loop would see a dead band between adjacent counts.

The command is read once per output period, in the last clock cycle of the period in progress. A new value therefore never shortens or stretches a period that has already started. The integer count in use is kept between two parameter limits. The output is high for the first half of each period, rounded down, and low for the rest. A one-cycle strobe marks the first cycle of every period.

Top module: `vpo_dith_osc`

## Requirements
- R1: Consecutive `cyc_stb` pulses are exactly L system clock cycles apart, where L is the count chosen for that period (a command of 40.0 gives 40, and 41.0 gives 41).
- R2: `period_cmd` holds the integer part in its upper INT_W bits and a fraction of 2^FRAC_W in its lower FRAC_W bits (default 8/8). Each period adds the fraction to a residual. The carry out adds one to the integer part, and the residual keeps the remainder. After reset, a command of 14.5 gives the periods 14, 15, 14, 15.
- R3: After reset, a command of 14.25 gives the periods 14, 14, 14, 15, and the pattern repeats.
- R4: The command is sampled only in the final cycle of a period. Changes at any other time have no effect on period lengths.
- R5: The count, including the carry, is clamped to [MIN_CNT, MAX_CNT] (default 4 and 200). The residual keeps advancing even while the count is clamped.
- R6: `osc_out` is high for the first floor(L/2) cycles of each period and low for the rest. `cyc_stb` is high only in the first cycle.
- R7: While reset is asserted, both outputs are low and the residual is cleared. The first period starts on the first clock edge after reset is released.
- R8: Over 256 periods at a constant command, the total number of cycles equals 256 times the command. For example, 37.125 gives 9504 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_cmd | input | INT_W+FRAC_W | Fixed-point period command in clock cycles |
| osc_out | output | 1 | Registered oscillator output |
| cyc_stb | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The assertions assume nothing about `period_cmd` except that it is driven with known values. Any integer part, including values below MIN_CNT or above MAX_CNT, is legal and is caught by the clamp. The stimulus drives random commands whose integer parts range from below the lower limit to just past the upper one. It also scrambles the command at random points inside each period and restores the intended value only in the final cycle, which is when the block samples it. Most random integer parts are kept small so that the run stays short, and a few large values reach the upper clamp.

// File: rtl/vpo_pkg.sv
package vpo_pkg;

  // Saturate an unsigned value into the closed range [lo, hi]
  function automatic int unsigned sat_range(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/vpo_dither.sv
module vpo_dither #(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int MIN_CNT = 4,
  parameter int MAX_CNT = 200,
  parameter int LEN_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic [INT_W+FRAC_W-1:0] cmd,
  output logic [LEN_W-1:0]        next_len
);
  import vpo_pkg::*;

  logic [INT_W-1:0]  cmd_int;
  logic [FRAC_W-1:0] cmd_frac;
  logic [FRAC_W-1:0] resid_q;
  logic [FRAC_W:0]   acc;
  logic [INT_W:0]    raw;

  assign cmd_int  = cmd[INT_W+FRAC_W-1:FRAC_W];
  assign cmd_frac = cmd[FRAC_W-1:0];
  assign acc      = {1'b0, resid_q} + {1'b0, cmd_frac};
  assign raw      = {1'b0, cmd_int} + {{INT_W{1'b0}}, acc[FRAC_W]};

  always_comb begin
    next_len = LEN_W'(sat_range(int'(raw), MIN_CNT, MAX_CNT));
  end

  // Residual keeps the fractional remainder; it advances even when clamped
  always_ff @(posedge clk) begin
    if (rst) begin
      resid_q <= '0;
    end else if (take) begin
      resid_q <= acc[FRAC_W-1:0];
    end
  end

  // R5: the chosen length always lies inside the configured limits
  always_comb begin
    if (!rst && take) begin
      p_len_sat_r5: assert (next_len >= LEN_W'(MIN_CNT) && next_len <= LEN_W'(MAX_CNT))
        else $error("next_len out of range");
    end
  end

  // R7: residual is clear on the first edge after reset
  p_resid_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (resid_q == '0));

  // R4: residual only moves at a period boundary
  p_resid_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(resid_q));

  // R2: a zero fraction leaves the residual untouched
  p_zero_frac_r2: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_frac == '0) |=> $stable(resid_q));

endmodule

// File: rtl/vpo_timer.sv
module vpo_timer #(
  parameter int MIN_CNT = 4,
  parameter int MAX_CNT = 200,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] next_len,
  output logic             take,
  output logic             osc_out,
  output logic             cyc_stb
);

  logic             primed;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] phase_q;
  logic [LEN_W-1:0] phase_nx;
  logic             osc_q;
  logic             stb_q;

  assign phase_nx = phase_q + 1'b1;
  assign take     = !primed || (phase_q == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      len_q   <= LEN_W'(MIN_CNT);
      phase_q <= '0;
      osc_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else if (take) begin
      primed  <= 1'b1;
      len_q   <= next_len;
      phase_q <= '0;
      stb_q   <= 1'b1;
      osc_q   <= (next_len >> 1) != '0;
    end else begin
      phase_q <= phase_nx;
      stb_q   <= 1'b0;
      osc_q   <= phase_nx < (len_q >> 1);
    end
  end

  assign osc_out = osc_q;
  assign cyc_stb = stb_q;

  // R5: the active length stays within limits
  p_len_bounds_r5: assert property (@(posedge clk) disable iff (rst)
    primed |-> (len_q >= LEN_W'(MIN_CNT) && len_q <= LEN_W'(MAX_CNT)));

  // R1: the phase never runs past the period length
  p_phase_in_len_r1: assert property (@(posedge clk) disable iff (rst)
    primed |-> (phase_q < len_q));

  // R4: a running period keeps its length
  p_len_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (primed && !take) |=> $stable(len_q));

  // R6: the strobe lasts one cycle and falls in the high half
  p_stb_single_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_stb |=> !cyc_stb);
  p_stb_high_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_stb |-> osc_out);

  // R7: the first period starts right after reset release
  p_first_start_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst, 2) && !$past(rst)) |-> cyc_stb);

endmodule

// File: rtl/vpo_dith_osc.sv
module vpo_dith_osc #(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int MIN_CNT = 4,
  parameter int MAX_CNT = 200
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INT_W+FRAC_W-1:0] period_cmd,
  output logic                    osc_out,
  output logic                    cyc_stb
);
  localparam int LEN_W = $clog2(MAX_CNT + 1);

  logic             take;
  logic [LEN_W-1:0] next_len;

  vpo_dither #(
    .INT_W(INT_W), .FRAC_W(FRAC_W),
    .MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT), .LEN_W(LEN_W)
  ) u_dither (
    .clk(clk), .rst(rst), .take(take), .cmd(period_cmd), .next_len(next_len)
  );

  vpo_timer #(
    .MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT), .LEN_W(LEN_W)
  ) u_timer (
    .clk(clk), .rst(rst), .next_len(next_len),
    .take(take), .osc_out(osc_out), .cyc_stb(cyc_stb)
  );

endmodule

// File: tb/vpo_dith_osc_bench.sv
`timescale 1ns/1ps
module vpo_dith_osc_bench;
  localparam int IW = 8;
  localparam int FW = 8;
  localparam int LO = 4;
  localparam int HI = 200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   period_cmd = 16'h0E80;
  logic          osc_out;
  logic          cyc_stb;

  int total = 0;
  int fails = 0;
  int resid_m = 0;
  logic [15:0] edge_cmd = 16'h0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vpo_dith_osc #(.INT_W(IW), .FRAC_W(FW), .MIN_CNT(LO), .MAX_CNT(HI)) u_vpo_dith_osc (
    .clk(clk), .rst(rst), .period_cmd(period_cmd), .osc_out(osc_out), .cyc_stb(cyc_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // Reference: fraction accumulates, carry adds one, then clamp
  function automatic int model_len(logic [15:0] c);
    int s;
    int raw;
    s = resid_m + int'(c[7:0]);
    raw = int'(c[15:8]) + ((s >= 256) ? 1 : 0);
    resid_m = s % 256;
    if (raw < LO) raw = LO;
    if (raw > HI) raw = HI;
    return raw;
  endfunction

  task automatic restart(input logic [15:0] c);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(osc_out == 1'b0, "R7 osc in reset", int'(osc_out), 0);
    check(cyc_stb == 1'b0, "R7 stb in reset", int'(cyc_stb), 0);
    period_cmd = c;
    rst = 1'b0;
    @(negedge clk);
    check(cyc_stb == 1'b1, "R7 first strobe", int'(cyc_stb), 1);
    resid_m = 0;
    edge_cmd = c;
  endtask

  // Called at a negedge just after a strobe; measures that period
  task automatic run_period(input logic [15:0] nxt, input bit scramble,
                            input string tag, output int got);
    int exp;
    int cnt;
    int hi;
    exp = model_len(edge_cmd);
    cnt = 1;
    hi = int'(osc_out);
    period_cmd = scramble ? 16'($urandom) : nxt;
    forever begin
      @(negedge clk);
      if (cyc_stb) break;
      cnt++;
      hi += int'(osc_out);
      if (cnt > 400) break;
      if (cnt >= exp) period_cmd = nxt;
      else if (scramble) period_cmd = 16'($urandom);
    end
    check(cnt == exp, tag, cnt, exp);
    check(hi == exp / 2, "R6 high cycles", hi, exp / 2);
    edge_cmd = nxt;
    got = cnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int g;
    int sum;
    int pat[4];
    void'($urandom(32'd20240611));

    // R2: 14.5 alternates 14 and 15
    restart(16'h0E80);
    pat = '{14, 15, 14, 15};
    for (int i = 0; i < 4; i++) begin
      run_period(16'h0E80, 1'b0, "R2 half step", g);
      check(g == pat[i], "R2 alternation", g, pat[i]);
    end

    // R3: 14.25 repeats 14,14,14,15 after reset
    restart(16'h0E40);
    pat = '{14, 14, 14, 15};
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 4; i++) begin
        run_period(16'h0E40, 1'b0, "R3 quarter step", g);
        check(g == pat[i], "R3 pattern", g, pat[i]);
      end

    // R1: integer periods, even and odd
    for (int i = 0; i < 3; i++) run_period(16'h2800, 1'b0, "R1 count 40", g);
    for (int i = 0; i < 3; i++) run_period(16'h2900, 1'b0, "R1 count 41", g);
    run_period(16'h2700, 1'b0, "R1 count 39", g);
    check(g == 41, "R1 odd period", g, 41);

    // R5: clamps at both ends, residual still moving
    for (int i = 0; i < 3; i++) run_period(16'h0100, 1'b0, "R5 low clamp", g);
    check(g == LO, "R5 low clamp value", g, LO);
    for (int i = 0; i < 3; i++) run_period(16'hFA00, 1'b0, "R5 high clamp", g);
    check(g == HI, "R5 high clamp value", g, HI);
    for (int i = 0; i < 3; i++) run_period(16'hC880, 1'b0, "R5 clamp with carry", g);
    for (int i = 0; i < 4; i++) run_period(16'h1440, 1'b0, "R5 after clamp", g);

    // R4: command scrambled mid-period must not matter
    for (int i = 0; i < 20; i++) run_period(16'h1A60, 1'b1, "R4 mid-period change", g);

    // R8: long-run average of 37.125
    run_period(16'h2520, 1'b0, "R8 settle", g);
    sum = 0;
    for (int i = 0; i < 256; i++) begin
      run_period(16'h2520, 1'b0, "R8 period", g);
      sum += g;
    end
    check(sum == 9504, "R8 average", sum, 9504);

    // Random commands with mid-period scrambling
    for (int i = 0; i < 200; i++) begin
      logic [15:0] c;
      c[7:0]  = 8'($urandom);
      c[15:8] = ($urandom % 16 == 0) ? 8'(190 + $urandom % 20) : 8'(1 + $urandom % 60);
      run_period(c, ($urandom % 2) == 1, "R2 random command", g);
    end

    finish_up();
  end
endmodule